// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control and address pins of a DDR SDRAM command bus from the memory side and samples them on every rising clock edge. It turns each pin pattern into a compact command code and presents the bank, row, column and auto-precharge fields that belong to that command. It also keeps a model of the four banks: whether each is idle, open or closing after an auto-precharge access, and which row each one holds. It follows which burst is running, so that a burst stop can be judged, and whether the device sits in self refresh. A single flag marks any command that is not allowed in the current state.

All outputs are registered and appear one clock after the edge that sampled the command. Legality is always judged against the state held before that edge. A command flagged illegal changes no bank, burst, power or mode-register state. Three enumerated machines carry the state. Each bank has a machine with states Idle, Open and AutoPre. The Idle to Open transition is taken on an accepted activate. Open moves to AutoPre on an accepted read or write with auto-precharge. Any state returns to Idle on a matching precharge, and AutoPre also returns to Idle when its countdown expires. The burst machine has states None, Read, ReadAp and Write. A start loads a countdown, and the machine returns to None when a legal burst stop arrives or when the countdown runs out. The power machine has states Run and Self. Run moves to Self on an accepted refresh with CKE low, and Self returns to Run on the first edge that samples CKE high.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With cs_n high, the command is decoded as NOP (cmd_code 0) whatever ras_n, cas_n, we_n, ba and addr carry. With cs_n low and ras_n, cas_n, we_n all high, it is also NOP. Neither raises illegal.
- R2: With cs_n low, {ras_n,cas_n,we_n} decodes as 011 ACTIVE (code 1), 101 READ (2), 100 WRITE (3), 110 BURST STOP (4), 010 PRECHARGE (5), 001 REFRESH (6) and 000 LOAD MODE (7). The code appears on cmd_code one clock after the sampling edge. At most one of mr_wr, auto_ref and illegal is high in any cycle.
- R3: An ACTIVE to an idle bank sets bank_open[ba] and stores addr in bank_rows[ba*13 +: 13], and cmd_row shows addr. An ACTIVE to a bank that is not idle raises illegal and changes nothing.
- R4: For READ and WRITE, cmd_col is {addr[11], addr[9:0]}, cmd_ap is addr[10] and cmd_bank is ba. A READ or WRITE to a bank that is idle or already auto-precharging raises illegal.
- R5: After an accepted READ or WRITE with addr[10] high, bank_open of that bank clears on the BURST_LEN-th edge after the command edge. An ACTIVE sampled on that expiry edge or earlier is illegal.
- R6: PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes every bank regardless of ba. PRECHARGE is never illegal.
- R7: LOAD MODE with ba=0 pulses mr_wr with mr_sel=0 and loads mode_reg from addr. With ba=1 it pulses mr_wr with mr_sel=1 and loads emode_reg. With ba[1] high it raises illegal, gives no strobe and leaves both registers unchanged.
- R8: A legal REFRESH with cke high pulses auto_ref. With cke low it raises self_ref instead. For REFRESH, cmd_bank, cmd_row, cmd_col and cmd_ap read zero whatever ba and addr carry.
- R9: While in self refresh, every command is ignored: cmd_code is 0, illegal stays low and no bank or register changes. self_ref clears after the first edge that samples cke high.
- R10: BURST STOP is legal only within the BURST_LEN edges that follow an accepted READ without auto-precharge, and only until one stop has been accepted. During a READ with auto-precharge, during a WRITE, or with no burst running, it raises illegal.
- R11: REFRESH raises illegal unless all four banks are idle.
- R12: A synchronous active-high rst closes all banks, clears the stored rows, mode_reg, emode_reg, all strobes, illegal and self_ref, and returns to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; chooses auto or self refresh, ends self refresh |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus; bit 10 is the auto-precharge / all-banks bit |
| cmd_code | output | 3 | Decoded command code (see R2) |
| cmd_bank | output | 2 | Bank of the command, zero where not used |
| cmd_row | output | 13 | Row of an ACTIVE, zero otherwise |
| cmd_col | output | 11 | Column of a READ or WRITE, zero otherwise |
| cmd_ap | output | 1 | addr[10] for READ, WRITE, PRECHARGE |
| mr_wr | output | 1 | One-cycle pulse on a legal LOAD MODE |
| mr_sel | output | 1 | 0 = mode register, 1 = extended mode register |
| mode_reg | output | 13 | Current mode register contents |
| emode_reg | output | 13 | Current extended mode register contents |
| auto_ref | output | 1 | One-cycle pulse on a legal auto refresh |
| self_ref | output | 1 | High while in self refresh |
| illegal | output | 1 | One-cycle pulse for a command not allowed in the current state |
| bank_open | output | 4 | Per-bank row-open flag (Open or AutoPre) |
| bank_rows | output | 52 | Row held by each bank, bank n at bits n*13 +: 13 |

## Verification
The tightest collision is the expiry of an auto-precharge countdown in the same cycle that a new command reaches the same bank. An ACTIVE, a READ or a REFRESH arriving on the expiry edge must still see the bank as busy, and the next edge must see it idle. The bench provokes this directly: it issues a READ with auto-precharge, waits exactly BURST_LEN edges, sends ACTIVE to that bank, and expects illegal. It then repeats the ACTIVE one edge later and expects acceptance. The random phase reaches the same coincidence, and also a burst stop that lands on the last edge of a read burst. Every cycle is judged against a cycle-level reference model in the bench that updates the bank, burst and power state in the same edge order.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_LMR = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTOPRE = 2'd2
    } bank_st_e;

    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_READ    = 2'd1,
        BR_READ_AP = 2'd2,
        BR_WRITE   = 2'd3
    } burst_st_e;

    typedef enum logic {
        PW_RUN  = 1'b0,
        PW_SELF = 1'b1
    } pwr_st_e;

endpackage

// File: rtl/sdram_pin_decode.sv
module sdram_pin_decode
    import sdram_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    always_comb begin
        if (cs_n) begin
            cmd = CMD_NOP;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot
    import sdram_cmd_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_go,
    input  logic             ap_go,
    input  logic             close_go,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_idle,
    output logic             is_ready,
    output logic [ROW_W-1:0] row_q
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    bank_st_e         st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            BK_IDLE: begin
                if (act_go) st_d = BK_OPEN;
            end
            BK_OPEN: begin
                if (close_go) begin
                    st_d = BK_IDLE;
                end else if (ap_go) begin
                    st_d  = BK_AUTOPRE;
                    cnt_d = CNT_W'(BURST_LEN);
                end
            end
            BK_AUTOPRE: begin
                if (close_go || cnt_q == CNT_W'(1)) begin
                    st_d = BK_IDLE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            if (act_go) row_q <= row_in;
        end
    end

    always_comb begin
        is_idle  = (st_q == BK_IDLE);
        is_ready = (st_q == BK_OPEN);
    end

    // R3: the control layer only opens a bank that is idle
    assert_act_on_idle_R3: assert property (@(posedge clk) disable iff (rst)
        act_go |-> st_q == BK_IDLE);

    // R4: an auto-precharge access only targets an open bank
    assert_ap_on_open_R4: assert property (@(posedge clk) disable iff (rst)
        ap_go |-> st_q == BK_OPEN);

    // R5: the countdown's last cycle lands the bank in idle
    assert_ap_expiry_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_AUTOPRE && cnt_q == CNT_W'(1)) |=> is_idle);

endmodule

// File: rtl/sdram_burst_track.sv
module sdram_burst_track
    import sdram_cmd_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_rd,
    input  logic      start_wr,
    input  logic      with_ap,
    input  logic      stop,
    output burst_st_e state
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    burst_st_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (start_rd) begin
            st_d  = with_ap ? BR_READ_AP : BR_READ;
            cnt_d = CNT_W'(BURST_LEN);
        end else if (start_wr) begin
            st_d  = BR_WRITE;
            cnt_d = CNT_W'(BURST_LEN);
        end else if (stop) begin
            st_d = BR_NONE;
        end else begin
            unique case (st_q)
                BR_NONE: st_d = BR_NONE;
                BR_READ, BR_READ_AP, BR_WRITE: begin
                    if (cnt_q == CNT_W'(1)) st_d = BR_NONE;
                    else                    cnt_d = cnt_q - CNT_W'(1);
                end
                default: st_d = BR_NONE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= BR_NONE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb state = st_q;

    // R10: a stop is only accepted during a plain read burst
    assert_stop_in_plain_read_R10: assert property (@(posedge clk) disable iff (rst)
        stop |-> st_q == BR_READ);

    // R10: an accepted stop leaves no burst running
    assert_stop_ends_burst_R10: assert property (@(posedge clk) disable iff (rst)
        (stop && !start_rd && !start_wr) |=> st_q == BR_NONE);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
    import sdram_cmd_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int BURST_LEN = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic                          cke,
    input  logic [BA_W-1:0]               ba,
    input  logic [ADDR_W-1:0]             addr,
    output logic [2:0]                    cmd_code,
    output logic [BA_W-1:0]               cmd_bank,
    output logic [ADDR_W-1:0]             cmd_row,
    output logic [AP_BIT:0]               cmd_col,
    output logic                          cmd_ap,
    output logic                          mr_wr,
    output logic                          mr_sel,
    output logic [ADDR_W-1:0]             mode_reg,
    output logic [ADDR_W-1:0]             emode_reg,
    output logic                          auto_ref,
    output logic                          self_ref,
    output logic                          illegal,
    output logic [(2**BA_W)-1:0]          bank_open,
    output logic [(2**BA_W)*ADDR_W-1:0]   bank_rows
);

    localparam int NUM_BANKS = 2 ** BA_W;
    localparam int COL_W     = AP_BIT + 1;

    cmd_e                 pin_cmd, cmd_eff;
    pwr_st_e              pwr_q, pwr_d;
    burst_st_e            burst_st;
    logic [NUM_BANKS-1:0] bk_idle, bk_ready, act_go, ap_go, close_go;
    logic                 a10, legal, all_idle;
    logic [COL_W-1:0]     col_w;

    assign a10   = addr[AP_BIT];
    assign col_w = {addr[AP_BIT+1], addr[AP_BIT-1:0]};

    sdram_pin_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (pin_cmd)
    );

    always_comb cmd_eff = (pwr_q == PW_SELF) ? CMD_NOP : pin_cmd;
    always_comb all_idle = &bk_idle;

    always_comb begin
        unique case (cmd_eff)
            CMD_ACT:         legal = bk_idle[ba];
            CMD_RD, CMD_WR:  legal = bk_ready[ba];
            CMD_BST:         legal = (burst_st == BR_READ);
            CMD_REF:         legal = all_idle;
            CMD_LMR:         legal = (ba <= BA_W'(1));
            default:         legal = 1'b1;
        endcase
    end

    // power state machine: register process
    always_ff @(posedge clk) begin
        if (rst) pwr_q <= PW_RUN;
        else     pwr_q <= pwr_d;
    end

    always_comb begin
        pwr_d = pwr_q;
        unique case (pwr_q)
            PW_RUN:  if (cmd_eff == CMD_REF && legal && !cke) pwr_d = PW_SELF;
            PW_SELF: if (cke) pwr_d = PW_RUN;
            default: pwr_d = PW_RUN;
        endcase
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        always_comb begin
            act_go[g]   = (cmd_eff == CMD_ACT) && legal && (ba == BA_W'(g));
            ap_go[g]    = ((cmd_eff == CMD_RD) || (cmd_eff == CMD_WR)) && legal
                          && a10 && (ba == BA_W'(g));
            close_go[g] = (cmd_eff == CMD_PRE) && (a10 || ba == BA_W'(g));
        end

        sdram_bank_slot #(
            .ROW_W     (ADDR_W),
            .BURST_LEN (BURST_LEN)
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .act_go   (act_go[g]),
            .ap_go    (ap_go[g]),
            .close_go (close_go[g]),
            .row_in   (addr),
            .is_idle  (bk_idle[g]),
            .is_ready (bk_ready[g]),
            .row_q    (bank_rows[g*ADDR_W +: ADDR_W])
        );

        assign bank_open[g] = !bk_idle[g];
    end

    sdram_burst_track #(
        .BURST_LEN (BURST_LEN)
    ) u_burst (
        .clk      (clk),
        .rst      (rst),
        .start_rd ((cmd_eff == CMD_RD) && legal),
        .start_wr ((cmd_eff == CMD_WR) && legal),
        .with_ap  (a10),
        .stop     ((cmd_eff == CMD_BST) && legal),
        .state    (burst_st)
    );

    // output process
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_code  <= 3'd0;
            cmd_bank  <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_ap    <= 1'b0;
            mr_wr     <= 1'b0;
            mr_sel    <= 1'b0;
            mode_reg  <= '0;
            emode_reg <= '0;
            auto_ref  <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            cmd_code <= cmd_eff;
            illegal  <= !legal;
            mr_wr    <= (cmd_eff == CMD_LMR) && legal;
            auto_ref <= (cmd_eff == CMD_REF) && legal && cke;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
            cmd_ap   <= 1'b0;
            mr_sel   <= 1'b0;
            unique case (cmd_eff)
                CMD_ACT: begin
                    cmd_bank <= ba;
                    cmd_row  <= addr;
                end
                CMD_RD, CMD_WR: begin
                    cmd_bank <= ba;
                    cmd_col  <= col_w;
                    cmd_ap   <= a10;
                end
                CMD_PRE: begin
                    cmd_bank <= ba;
                    cmd_ap   <= a10;
                end
                CMD_LMR: begin
                    cmd_bank <= ba;
                    if (legal) begin
                        mr_sel <= ba[0];
                        if (ba[0]) emode_reg <= addr;
                        else       mode_reg  <= addr;
                    end
                end
                default: ;
            endcase
        end
    end

    assign self_ref = (pwr_q == PW_SELF);

    // R2: strobes never coincide
    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mr_wr, auto_ref, illegal}));

    // R9: once settled in self refresh, the decoder stays quiet
    assert_quiet_in_self_R9: assert property (@(posedge clk) disable iff (rst)
        (self_ref && $past(self_ref)) |-> (cmd_code == 3'd0 && !illegal));

    // R11: an auto refresh is only reported with every bank closed
    assert_refresh_all_closed_R11: assert property (@(posedge clk) disable iff (rst)
        auto_ref |-> bank_open == '0);

    // R7: a mode write only ever reports bank 0 or 1
    assert_lmr_select_R7: assert property (@(posedge clk) disable iff (rst)
        mr_wr |-> (cmd_bank <= BA_W'(1) && mr_sel == cmd_bank[0]));

    // R9: self refresh freezes the bank state
    assert_banks_frozen_in_self_R9: assert property (@(posedge clk) disable iff (rst)
        (self_ref && $past(self_ref)) |-> $stable(bank_rows));

endmodule

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;

    localparam int CLK_P = 10;
    localparam int BL    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;

    logic [2:0]  cmd_code;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_row;
    logic [10:0] cmd_col;
    logic        cmd_ap, mr_wr, mr_sel, auto_ref, self_ref, illegal;
    logic [12:0] mode_reg, emode_reg;
    logic [3:0]  bank_open;
    logic [51:0] bank_rows;

    int checks = 0;
    int errors = 0;

    sdram_cmd_tracker #(.BA_W(2), .ADDR_W(13), .AP_BIT(10), .BURST_LEN(BL)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_ap(cmd_ap), .mr_wr(mr_wr),
        .mr_sel(mr_sel), .mode_reg(mode_reg), .emode_reg(emode_reg), .auto_ref(auto_ref),
        .self_ref(self_ref), .illegal(illegal), .bank_open(bank_open), .bank_rows(bank_rows)
    );

    always #(CLK_P/2) clk = ~clk;

    // reference model state
    int          m_bk[4];
    int          m_cnt[4];
    logic [12:0] m_row[4];
    int          m_br, m_brc;
    bit          m_self;
    logic [12:0] m_mode, m_emode;

    // expected outputs
    logic [2:0]  e_code;
    logic [1:0]  e_bank;
    logic [12:0] e_row;
    logic [10:0] e_col;
    logic        e_ap, e_mrw, e_mrsel, e_aref, e_ill;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int dec(logic c, logic r, logic a, logic w);
        if (c) return 0;
        case ({r, a, w})
            3'b111: return 0;
            3'b011: return 1;
            3'b101: return 2;
            3'b100: return 3;
            3'b110: return 4;
            3'b010: return 5;
            3'b001: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_bk[i] = 0; m_cnt[i] = 0; m_row[i] = '0; end
        m_br = 0; m_brc = 0; m_self = 0; m_mode = '0; m_emode = '0;
        e_code = 0; e_bank = 0; e_row = 0; e_col = 0; e_ap = 0;
        e_mrw = 0; e_mrsel = 0; e_aref = 0; e_ill = 0;
    endtask

    task automatic model_step(input logic c, r, a, w, k, input logic [1:0] b, input logic [12:0] ad);
        int  code;
        bit  leg, allidle;
        code = m_self ? 0 : dec(c, r, a, w);
        allidle = 1;
        for (int i = 0; i < 4; i++) if (m_bk[i] != 0) allidle = 0;
        case (code)
            1: leg = (m_bk[b] == 0);
            2, 3: leg = (m_bk[b] == 1);
            4: leg = (m_br == 1);
            6: leg = allidle;
            7: leg = (b <= 2'd1);
            default: leg = 1;
        endcase
        e_code = 3'(code);
        e_ill = !leg;
        e_mrw = (code == 7) && leg;
        e_mrsel = e_mrw ? b[0] : 1'b0;
        if (e_mrw) begin if (b[0]) m_emode = ad; else m_mode = ad; end
        e_aref = (code == 6) && leg && k;
        e_bank = (code == 1 || code == 2 || code == 3 || code == 5 || code == 7) ? b : 2'd0;
        e_row = (code == 1) ? ad : 13'd0;
        e_col = (code == 2 || code == 3) ? {ad[11], ad[9:0]} : 11'd0;
        e_ap = (code == 2 || code == 3 || code == 5) ? ad[10] : 1'b0;
        if (m_self) begin
            if (k) m_self = 0;
        end else if (code == 6 && leg && !k) m_self = 1;
        for (int i = 0; i < 4; i++) begin
            if (code == 5 && (ad[10] || b == 2'(i))) m_bk[i] = 0;
            else if (code == 1 && leg && b == 2'(i)) begin m_bk[i] = 1; m_row[i] = ad; end
            else if ((code == 2 || code == 3) && leg && ad[10] && b == 2'(i)) begin
                m_bk[i] = 2; m_cnt[i] = BL;
            end else if (m_bk[i] == 2) begin
                if (m_cnt[i] == 1) m_bk[i] = 0; else m_cnt[i]--;
            end
        end
        if (code == 2 && leg) begin m_br = ad[10] ? 2 : 1; m_brc = BL; end
        else if (code == 3 && leg) begin m_br = 3; m_brc = BL; end
        else if (code == 4 && leg) m_br = 0;
        else if (m_br != 0) begin if (m_brc == 1) m_br = 0; else m_brc--; end
    endtask

    task automatic compare_all();
        logic [3:0]  eo;
        logic [51:0] er;
        for (int i = 0; i < 4; i++) begin
            eo[i] = (m_bk[i] != 0);
            er[i*13 +: 13] = m_row[i];
        end
        chk("R1/R2 cmd_code", 64'(cmd_code), 64'(e_code));
        chk("R4/R8 fields", 64'({cmd_bank, cmd_row, cmd_col, cmd_ap}), 64'({e_bank, e_row, e_col, e_ap}));
        chk("R7 mode", 64'({mr_wr, mr_sel, mode_reg, emode_reg}), 64'({e_mrw, e_mrsel, m_mode, m_emode}));
        chk("R8/R9 refresh", 64'({auto_ref, self_ref}), 64'({e_aref, m_self}));
        chk("R3/R5/R10/R11 illegal", 64'(illegal), 64'(e_ill));
        chk("R3/R5/R6 bank_open", 64'(bank_open), 64'(eo));
        chk("R3 bank_rows", 64'(bank_rows), 64'(er));
    endtask

    // drive at a negedge, then compare at the following negedge
    task automatic step(input logic c, r, a, w, k, input logic [1:0] b, input logic [12:0] ad);
        cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; ba = b; addr = ad;
        model_step(c, r, a, w, k, b, ad);
        @(negedge clk);
        compare_all();
    endtask

    // c: 0 NOP,1 ACT,2 RD,3 WR,4 BST,5 PRE,6 REF,7 LMR, 8 deselect
    task automatic issue(input int c, input logic [1:0] b, input logic [12:0] ad, input logic k);
        logic [2:0] p;
        case (c)
            1: p = 3'b011; 2: p = 3'b101; 3: p = 3'b100; 4: p = 3'b110;
            5: p = 3'b010; 6: p = 3'b001; 7: p = 3'b000; 8: p = 3'($urandom);
            default: p = 3'b111;
        endcase
        step(c == 8, p[2], p[1], p[0], k, b, ad);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; cke = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        compare_all();
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        @(negedge clk);
        do_reset();
        chk("R12 reset open", 64'(bank_open), 64'd0);
        chk("R12 reset flags", 64'({illegal, self_ref, mode_reg}), 64'd0);

        // R1: deselect with pins that would otherwise be LOAD MODE
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 13'h1FFF);
        chk("R1 deselect code", 64'(cmd_code), 64'd0);
        chk("R1 deselect legal", 64'(illegal), 64'd0);

        issue(1, 2'd1, 13'h1ABC, 1'b1);
        chk("R3 act open", 64'(bank_open[1]), 64'd1);
        chk("R3 act row", 64'(bank_rows[13 +: 13]), 64'h1ABC);
        issue(1, 2'd1, 13'h0001, 1'b1);
        chk("R3 act twice illegal", 64'(illegal), 64'd1);

        issue(2, 2'd1, 13'h0C55, 1'b1);
        chk("R4 column", 64'(cmd_col), 64'h455);
        chk("R4 ap bit", 64'(cmd_ap), 64'd1);
        issue(4, 2'd0, 13'h0, 1'b1);
        chk("R10 stop in ap read", 64'(illegal), 64'd1);
        issue(0, 2'd0, 13'h0, 1'b1);
        issue(0, 2'd0, 13'h0, 1'b1);
        issue(1, 2'd1, 13'h0222, 1'b1);   // lands on the expiry edge
        chk("R5 act on expiry edge", 64'(illegal), 64'd1);
        chk("R5 closed after expiry", 64'(bank_open[1]), 64'd0);
        issue(1, 2'd1, 13'h0222, 1'b1);
        chk("R5 act after expiry", 64'(illegal), 64'd0);

        issue(2, 2'd1, 13'h0000, 1'b1);
        issue(4, 2'd0, 13'h0, 1'b1);
        chk("R10 stop in plain read", 64'(illegal), 64'd0);
        issue(3, 2'd1, 13'h0000, 1'b1);
        issue(4, 2'd0, 13'h0, 1'b1);
        chk("R10 stop in write", 64'(illegal), 64'd1);

        issue(1, 2'd2, 13'h0333, 1'b1);
        issue(6, 2'd0, 13'h0, 1'b1);
        chk("R11 refresh with open bank", 64'(illegal), 64'd1);
        issue(5, 2'd0, 13'h0400, 1'b1);
        chk("R6 precharge all", 64'(bank_open), 64'd0);
        issue(1, 2'd0, 13'h0011, 1'b1);
        issue(1, 2'd3, 13'h0033, 1'b1);
        issue(5, 2'd3, 13'h0000, 1'b1);
        chk("R6 precharge one", 64'(bank_open), 64'b0001);
        issue(5, 2'd2, 13'h0400, 1'b1);

        issue(7, 2'd1, 13'h0123, 1'b1);
        chk("R7 ext mode", 64'({mr_wr, mr_sel, emode_reg}), 64'({1'b1, 1'b1, 13'h0123}));
        issue(7, 2'd2, 13'h1555, 1'b1);
        chk("R7 reserved select", 64'({illegal, mr_wr, emode_reg}), 64'({1'b1, 1'b0, 13'h0123}));
        issue(7, 2'd0, 13'h0031, 1'b1);
        chk("R7 mode", 64'({mr_sel, mode_reg}), 64'({1'b0, 13'h0031}));

        issue(6, 2'd3, 13'h1FFF, 1'b1);
        chk("R8 auto refresh", 64'({auto_ref, cmd_bank, cmd_row}), 64'({1'b1, 2'd0, 13'd0}));
        issue(6, 2'd0, 13'h0, 1'b0);
        chk("R8 self entry", 64'(self_ref), 64'd1);
        issue(1, 2'd0, 13'h0077, 1'b0);
        chk("R9 ignored act", 64'({cmd_code, illegal, bank_open}), 64'd0);
        issue(7, 2'd3, 13'h0077, 1'b0);
        chk("R9 ignored lmr", 64'({illegal, mr_wr}), 64'd0);
        issue(0, 2'd0, 13'h0, 1'b1);
        chk("R9 self exit", 64'(self_ref), 64'd0);

        for (int n = 0; n < 4000; n++) begin
            int r, c;
            logic k;
            r = int'($urandom % 100);
            if      (r < 8)  c = 8;
            else if (r < 14) c = 0;
            else if (r < 34) c = 1;
            else if (r < 52) c = 2;
            else if (r < 64) c = 3;
            else if (r < 72) c = 4;
            else if (r < 84) c = 5;
            else if (r < 89) c = 6;
            else if (r < 95) c = 7;
            else             c = 0;
            if (m_self)       k = ($urandom % 4 == 0);
            else if (c == 6)  k = ($urandom % 3 != 0);
            else              k = 1'b1;
            issue(c, 2'($urandom), 13'($urandom), k);
        end

        // R12: reset in the middle of activity
        issue(1, 2'd0, 13'h0AAA, 1'b1);
        issue(7, 2'd0, 13'h0ABC, 1'b1);
        do_reset();
        chk("R12 mid reset", 64'({bank_open, mode_reg, illegal}), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule